// File: doc/BRIEF.md
# Segment Descriptor Fetch and Validation Unit

This unit takes a table index and a requested access kind (read, write or execute) and fetches the matching 8-byte segment descriptor from a table in memory. A 48-bit table register gives the table's location: a 32-bit base and a 16-bit byte limit. The unit rejects the null entry and any entry outside the table before it touches memory. For any other entry it reads the two 32-bit words that make up the descriptor over a simple request/acknowledge port. It then decodes the scattered base and limit fields, applies byte or 4 KiB granularity, and checks the segment class, the presence bit and the access rights.

The unit returns the segment base, the effective limit, the default-size flag and the meaning of descriptor bit 42, with a fault code, in a single `done` pulse. If a check passes on an entry whose accessed bit is still clear, the unit first writes the upper word back with that bit set. One request is handled at a time. The next request is presented after `done`.

Top module: `seg_desc_checker`

## Requirements
- R1: After synchronous reset, `done` and `mem_req` are low and stay low until a request arrives.
- R2: A request for index 0 finishes with fault code 1 (null) and makes no memory access.
- R3: If the entry's last byte (index*8+7) is greater than `tbl_limit`, the request finishes with fault code 2 (limit) and makes no memory access. An entry whose last byte equals the limit is fetched normally.
- R4: The low word is read at `tbl_base`+index*8 and then the high word at that address +4. Each request is held with a stable address until `mem_ack`.
- R5: The segment base is high[31:24], high[7:0] and low[31:16], from most to least significant.
- R6: The raw 20-bit limit is high[19:16] above low[15:0]. When the granularity bit high[23] is 1, the effective limit is raw*4096+4095. Otherwise it equals the raw value.
- R7: When the class bit high[12] is 0 (system segment), the request finishes with fault code 3 and no further checks are made.
- R8: When the class bit is 1 and the present bit high[15] is 0, the request finishes with fault code 4.
- R9: The executable bit is high[11]. For code (1), a write, or a read with high[9]=0, gives fault code 5. For data (0), an execute, or a write with high[9]=0, gives fault code 5. Kind encoding: 0 read, 1 write, 2 or 3 execute.
- R10: `seg_conforming` is high[10] for a code segment. `seg_expand_down` is high[10] for a data segment. The other output is 0 in each case.
- R11: `seg_big` reports high[22]. The spare bit high[20] has no effect on any output.
- R12: On success with the accessed bit high[8] at 0, the unit writes the high word with bit 8 set to address +4 before `done`. It makes no write when the bit is already set or when the request faults.
- R13: Each request gives exactly one one-cycle `done` pulse. Success carries fault code 0. On a fault, base, limit and the three flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup (sampled while idle) |
| req_index | input | IDX_W | Table entry index |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| tbl_base | input | ADDR_W | Table base address |
| tbl_limit | input | TLIM_W | Table byte limit |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 3 | 0 ok, 1 null, 2 limit, 3 system, 4 absent, 5 type |
| seg_base | output | 32 | Segment base |
| seg_limit | output | 32 | Effective segment limit |
| seg_big | output | 1 | Default 32-bit operand size |
| seg_conforming | output | 1 | Code segment is conforming |
| seg_expand_down | output | 1 | Data segment expands downward |

## Verification
The assertions assume that memory gives exactly one `mem_ack` for each request and raises it only while `mem_req` is high. They also assume that `req_valid` is pulsed only while the unit is idle and that the table register stays stable during a lookup. The bench's memory model acknowledges one cycle after it sees a request and drops the acknowledge the cycle after. The driver raises `req_valid` for a single cycle and waits for the scoreboard to see `done` before it issues the next request.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

    localparam int WORD_W     = 32;
    localparam int RAW_LIM_W  = 20;
    localparam int PAGE_SHIFT = 12;
    localparam int ACC_BIT    = 8;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_LIMIT  = 3'd2,
        FLT_SYSTEM = 3'd3,
        FLT_ABSENT = 3'd4,
        FLT_TYPE   = 3'd5
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_WRBACK, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]    base;
        logic [RAW_LIM_W-1:0] raw_limit;
        logic                 gran;
        logic                 big;
        logic                 present;
        logic [1:0]           dpl;
        logic                 user_seg;
        logic                 exec;
        logic                 flag42;
        logic                 flag41;
        logic                 accessed;
    } desc_t;

    typedef struct packed {
        fault_e            fault;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] limit;
        logic              big;
        logic              conforming;
        logic              expand_down;
    } result_t;

    function automatic desc_t unpack_desc(input logic [WORD_W-1:0] lo,
                                          input logic [WORD_W-1:0] hi);
        desc_t d;
        d.base      = {hi[31:24], hi[7:0], lo[31:16]};
        d.raw_limit = {hi[19:16], lo[15:0]};
        d.gran      = hi[23];
        d.big       = hi[22];
        d.present   = hi[15];
        d.dpl       = hi[14:13];
        d.user_seg  = hi[12];
        d.exec      = hi[11];
        d.flag42    = hi[10];
        d.flag41    = hi[9];
        d.accessed  = hi[ACC_BIT];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] scale_limit(input logic [RAW_LIM_W-1:0] raw,
                                                      input logic gran);
        logic [WORD_W-1:0] wide;
        wide = WORD_W'(raw);
        if (gran)
            return (wide << PAGE_SHIFT) | WORD_W'((1 << PAGE_SHIFT) - 1);
        return wide;
    endfunction

    function automatic fault_e judge(input desc_t d, input logic [1:0] kind);
        logic is_rd, is_wr, is_ex;
        is_rd = (kind == KIND_READ);
        is_wr = (kind == KIND_WRITE);
        is_ex = !is_rd && !is_wr;
        if (!d.user_seg)
            return FLT_SYSTEM;
        if (!d.present)
            return FLT_ABSENT;
        if (d.exec) begin
            if (is_wr || (is_rd && !d.flag41))
                return FLT_TYPE;
        end else begin
            if (is_ex || (is_wr && !d.flag41))
                return FLT_TYPE;
        end
        return FLT_NONE;
    endfunction

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_desc_pkg::*;
(
    input  logic [WORD_W-1:0] lo_word,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [1:0]        kind,
    output result_t           res,
    output logic              need_wb
);

    desc_t  d;
    fault_e verdict;

    always_comb begin
        d       = unpack_desc(lo_word, hi_word);
        verdict = judge(d, kind);
        res     = '0;
        res.fault = verdict;
        if (verdict == FLT_NONE) begin
            res.base        = d.base;
            res.limit       = scale_limit(d.raw_limit, d.gran);
            res.big         = d.big;
            res.conforming  = d.exec && d.flag42;
            res.expand_down = !d.exec && d.flag42;
        end
        need_wb = (verdict == FLT_NONE) && !d.accessed;
    end

endmodule

// File: rtl/seg_fetch_seq.sv
module seg_fetch_seq
    import seg_desc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              early_stop,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic              need_wb,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output seq_state_e        state,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q
);

    localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(WORD_W / 8);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ent_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = early_stop ? ST_DONE : ST_RD_LO;
            ST_RD_LO:  if (mem_ack) state_d = ST_RD_HI;
            ST_RD_HI:  if (mem_ack) state_d = ST_CHECK;
            ST_CHECK:  state_d = need_wb ? ST_WRBACK : ST_DONE;
            ST_WRBACK: if (mem_ack) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ent_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start)
                ent_q <= entry_addr;
            if (state_q == ST_RD_LO && mem_ack)
                lo_q <= mem_rdata;
            if (state_q == ST_RD_HI && mem_ack)
                hi_q <= mem_rdata;
        end
    end

    always_comb begin
        state     = state_q;
        mem_req   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI) || (state_q == ST_WRBACK);
        mem_we    = (state_q == ST_WRBACK);
        mem_addr  = (state_q == ST_RD_LO) ? ent_q : ent_q + HI_OFS;
        mem_wdata = hi_q | (WORD_W'(1) << ACC_BIT);
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4

endmodule

// File: rtl/seg_desc_checker.sv
module seg_desc_checker
    import seg_desc_pkg::*;
#(
    parameter int IDX_W  = 13,
    parameter int TLIM_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [TLIM_W-1:0] tbl_limit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              done,
    output logic [2:0]        fault,
    output logic [31:0]       seg_base,
    output logic [31:0]       seg_limit,
    output logic              seg_big,
    output logic              seg_conforming,
    output logic              seg_expand_down
);

    localparam int ENT_W = IDX_W + 3;
    localparam int CMP_W = (ENT_W > TLIM_W) ? ENT_W : TLIM_W;

    seq_state_e        state;
    logic [WORD_W-1:0] lo_q, hi_q;
    logic [1:0]        kind_q;
    logic              is_null, over_lim, early_stop, need_wb;
    logic [ADDR_W-1:0] entry_addr;
    result_t           dec_res, early_res, res_q;
    logic              accept;

    always_comb begin
        is_null    = (req_index == '0);
        over_lim   = CMP_W'({req_index, 3'b111}) > CMP_W'(tbl_limit);
        early_stop = is_null || over_lim;
        entry_addr = tbl_base + ADDR_W'({req_index, 3'b000});
        accept     = (state == ST_IDLE) && req_valid;
        early_res  = '0;
        early_res.fault = is_null ? FLT_NULL : FLT_LIMIT;
    end

    seg_fetch_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (req_valid),
        .early_stop (early_stop),
        .entry_addr (entry_addr),
        .need_wb    (need_wb),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .state      (state),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .lo_q       (lo_q),
        .hi_q       (hi_q)
    );

    seg_desc_decode u_dec (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .kind    (kind_q),
        .res     (dec_res),
        .need_wb (need_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            kind_q <= '0;
        end else begin
            if (accept) begin
                kind_q <= req_kind;
                if (early_stop)
                    res_q <= early_res;
            end
            if (state == ST_CHECK)
                res_q <= dec_res;
        end
    end

    always_comb begin
        done            = (state == ST_DONE);
        fault           = res_q.fault;
        seg_base        = res_q.base;
        seg_limit       = res_q.limit;
        seg_big         = res_q.big;
        seg_conforming  = res_q.conforming;
        seg_expand_down = res_q.expand_down;
    end

    AST_NULL_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (accept && is_null) |=> (!mem_req && done && fault == FLT_NULL)); // R2

    AST_LIMIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_null && over_lim) |=> (!mem_req && done && fault == FLT_LIMIT)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13

    AST_FAULT_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (done && fault != FLT_NONE) |-> (seg_base == '0 && seg_limit == '0 && !seg_big)); // R13

    AST_NO_WB_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && dec_res.fault != FLT_NONE) |=> (!mem_req && done)); // R12

endmodule

// File: tb/seg_desc_checker_tb_top.sv
module seg_desc_checker_tb_top;

    localparam int TB_BASE = 32'h100;
    localparam logic [15:0] TB_LIMIT = 16'h003F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [12:0] req_index = '0;
    logic [1:0]  req_kind = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done, seg_big, seg_conforming, seg_expand_down;
    logic [2:0]  fault;
    logic [31:0] seg_base, seg_limit;

    always #4 clk = ~clk;

    seg_desc_checker dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_kind(req_kind), .tbl_base(32'(TB_BASE)), .tbl_limit(TB_LIMIT),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_big(seg_big), .seg_conforming(seg_conforming),
        .seg_expand_down(seg_expand_down)
    );

    // memory model: ack one cycle after a request is seen
    logic [31:0] mem [0:255];
    logic        ack_r = 1'b0;
    logic [31:0] rdata_r = '0;
    int          acc_total = 0;
    assign mem_ack   = ack_r;
    assign mem_rdata = rdata_r;

    always @(posedge clk) begin
        if (mem_req && !ack_r) begin
            ack_r   <= 1'b1;
            rdata_r <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            acc_total = acc_total + 1;
        end else begin
            ack_r <= 1'b0;
        end
    end

    typedef struct {
        logic [2:0]  fault;
        logic [31:0] base;
        logic [31:0] limit;
        logic        big, conf, down;
        int          naccess;
        logic        wb;
        int          wb_word;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0, n_done = 0, acc_mark = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // monitor: pops scoreboard on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({t, " fault"}, 32'(fault), 32'(e.fault));
                chk({t, " base R5"}, seg_base, e.base);
                chk({t, " limit R6"}, seg_limit, e.limit);
                chk({t, " big R11"}, 32'(seg_big), 32'(e.big));
                chk({t, " conforming R10"}, 32'(seg_conforming), 32'(e.conf));
                chk({t, " expand_down R10"}, 32'(seg_expand_down), 32'(e.down));
                chk({t, " accesses R4"}, 32'(acc_total - acc_mark), 32'(e.naccess));
                if (e.wb) chk({t, " wb bit R12"}, 32'(mem[e.wb_word][8]), 32'd1);
            end
            acc_mark = acc_total;
            n_done++;
        end
    end

    task automatic run_case(string tag, int idx, logic [1:0] kind,
                            logic [31:0] base, logic [19:0] lim,
                            logic g, logic d, logic avl, logic p, logic s,
                            logic x, logic f42, logic f41, logic a);
        logic [31:0] lo, hi;
        exp_t e;
        int   tgt, w;
        logic tfault, ok, is_rd, is_wr;
        lo = {base[15:0], lim[15:0]};
        hi = {base[31:24], g, d, 1'b0, avl, lim[19:16], p, 2'b00, s, x, f42, f41, a, base[23:16]};
        w  = (TB_BASE >> 2) + idx * 2;
        e  = '{default: '0};
        is_rd = (kind == 2'd0);
        is_wr = (kind == 2'd1);
        if (idx == 0) e.fault = 3'd1;
        else if (idx * 8 + 7 > int'(TB_LIMIT)) e.fault = 3'd2;
        else begin
            mem[w]     = lo;
            mem[w + 1] = hi;
            tfault = x ? (is_wr || (is_rd && !f41)) : ((!is_rd && !is_wr) || (is_wr && !f41));
            if (!s) e.fault = 3'd3;
            else if (!p) e.fault = 3'd4;
            else if (tfault) e.fault = 3'd5;
            else e.fault = 3'd0;
        end
        ok = (e.fault == 3'd0);
        if (ok) begin
            e.base  = base;
            e.limit = g ? {lim, 12'hFFF} : {12'h000, lim};
            e.big   = d;
            e.conf  = x & f42;
            e.down  = !x & f42;
        end
        e.wb      = ok && !a;
        e.wb_word = w + 1;
        e.naccess = (e.fault == 3'd1 || e.fault == 3'd2) ? 0 : (2 + (e.wb ? 1 : 0));
        exp_q.push_back(e);
        tag_q.push_back(tag);
        tgt = n_done + 1;
        @(negedge clk);
        req_valid = 1'b1;
        req_index = 13'(idx);
        req_kind  = kind;
        @(negedge clk);
        req_valid = 1'b0;
        while (n_done < tgt) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);

        // args: tag idx kind base lim g d avl p s x f42 f41 a
        run_case("R2 null index", 0, 2'd0, 32'h0, 20'h0, 0,0,0,1,1,0,0,1,0);
        run_case("R3 beyond limit", 8, 2'd0, 32'h0, 20'h0, 0,0,0,1,1,0,0,1,0);
        run_case("R3 last entry fits", 7, 2'd0, 32'hCAFE_0000, 20'h00FFF, 0,0,0,1,1,0,0,1,1);
        run_case("R6 R12 page data read wb", 1, 2'd0, 32'h1234_5678, 20'h0008F, 1,0,0,1,1,0,0,1,0);
        run_case("R12 accessed set no wb", 1, 2'd0, 32'h1234_5678, 20'h0008F, 1,0,0,1,1,0,0,1,1);
        run_case("R10 conforming code exec", 2, 2'd2, 32'h0001_0000, 20'h0FFFF, 0,0,0,1,1,1,1,1,1);
        run_case("R7 system segment", 3, 2'd0, 32'h0, 20'h0, 0,0,0,0,0,0,0,1,0);
        run_case("R8 not present", 4, 2'd0, 32'h0, 20'h0, 0,0,0,0,1,0,0,1,0);
        run_case("R9 write to code", 5, 2'd1, 32'h0, 20'h1, 0,0,0,1,1,1,0,1,0);
        run_case("R9 read unreadable code", 5, 2'd0, 32'h0, 20'h1, 0,0,0,1,1,1,0,0,0);
        run_case("R9 exec data", 6, 2'd2, 32'h0, 20'h1, 0,0,0,1,1,0,0,1,0);
        run_case("R9 write readonly data", 6, 2'd1, 32'h0, 20'h1, 0,0,0,1,1,0,0,0,0);
        run_case("R10 R12 expand-down write", 6, 2'd1, 32'hA5C3_0F1E, 20'hABCDE, 0,0,0,1,1,0,1,1,0);
        run_case("R11 big with spare bit", 2, 2'd3, 32'hFEDC_BA98, 20'h12345, 1,1,1,1,1,1,0,0,1);
        run_case("R13 code read ok", 3, 2'd0, 32'h8000_0001, 20'h00000, 0,0,0,1,1,1,0,1,0);

        repeat (4) @(negedge clk);
        chk("R13 no extra done", 32'(n_done), 32'd15);
        chk("R13 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R13: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule